// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

This block takes eight edge-triggered interrupt inputs, ranks them by a fixed priority, and raises one interrupt line to a processor. A short acknowledge handshake returns an 8-bit vector for the winning input. Software programs the block through two register addresses, selected by `addr_i`. An initialisation sequence of up to four words sets the vector base, the cascade role and the end-of-interrupt mode. After that, command words set the mask, retire in-service levels and choose which register an even-address read returns.

Two instances form a 16-line system. The slave's `int_o` drives one master input. The master's `cas_o` drives the slave's `cas_i`. Both instances share the acknowledge strobe. When the master acknowledges an input that its cascade word marks as carrying a slave, it returns no vector. The slave whose identity matches `cas_i` returns the vector instead.

Top module: `pic_ctrl`

## Requirements
- R1: A write to address 0 with data bit 4 set starts initialisation. The next address-1 writes are taken in order as the vector base, then the cascade word (skipped when bit 1 of the first word is set, meaning single mode), then the mode word (taken only when bit 0 of the first word is set). `int_o` stays low until the sequence completes.
- R2: The mask register reads 0xFF after reset, and it is forced to 0xFF when initialisation starts. After initialisation, an address-1 write loads the mask, where a 1 blocks that input. An address-1 read always returns the mask.
- R3: The vector for input n is {base[7:3], n}. The low three bits of the base word are ignored. `vec_vld_o` is high for the one cycle after the clock edge that samples `inta_i`.
- R4: A request bit is set on a rising input edge. It clears when the input is low, and it clears when the input is acknowledged. A masked input still latches a request but does not raise `int_o`.
- R5: Priority is fixed, with input 0 highest. An unmasked request raises `int_o` only when its level is above every level in service, so a higher level can nest over a lower one.
- R6: Outside auto-EOI mode, an acknowledge sets the in-service bit of the winning input. An address-0 write with bits 7:5 = 011 and bits 4:3 = 00 clears in-service bit (data & 7). The value 0x20 clears the highest-priority in-service bit.
- R7: When bit 1 of the mode word is set (auto-EOI), an acknowledge never sets an in-service bit.
- R8: An address-0 write of 0x0A makes address-0 reads return the request register. A write of 0x0B makes them return the in-service register. The request register is selected after initialisation.
- R9: If no unmasked request is eligible when an acknowledge arrives, the vector is {base[7:3], 7} and no in-service bit is set.
- R10: In cascade mode, a master that acknowledges an input marked in its cascade bitmap sets that in-service bit, keeps `vec_vld_o` low, and shows the input number on `cas_o`. A slave answers an acknowledge only when `cas_i` equals the low three bits of its cascade word.
- R11: Address-0 writes outside initialisation that match no command above leave the mask, the in-service register and the read selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = this instance is the cascade master |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address (0 = even, 1 = odd) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_i | input | 8 | Interrupt inputs, edge-triggered |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| cas_i | input | 3 | Cascade select from the master (slave only) |
| cas_o | output | 3 | Cascade select to the slaves (master only) |
| vec_vld_o | output | 1 | Vector valid |
| vec_o | output | 8 | Interrupt vector |

## Verification
The assertions check a set of per-cycle facts:
- `int_o` is raised only after initialisation and only for an unmasked request.
- The mask stays all ones during initialisation.
- A request bit never outlives the input that set it.
- The in-service register stays empty in auto-EOI mode.
- A vector appears only after an acknowledge.

The bench scenarios cover the behaviour that depends on command order. That includes vector arithmetic for both instances, nesting and blocking by priority, specific and non-specific EOI, the spurious input-7 response, the skipped cascade word in single mode, and the master/slave handoff over `cas_o`.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int N_LVL  = 8;
  parameter int DATA_W = 8;
  localparam int LVL_W  = $clog2(N_LVL);
  localparam int BASE_W = DATA_W - LVL_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_READY
  } cfg_state_e;

  function automatic logic [N_LVL-1:0] lsb_oh(input logic [N_LVL-1:0] v);
    return v & (~v + N_LVL'(1));
  endfunction

  function automatic logic [LVL_W-1:0] oh2idx(input logic [N_LVL-1:0] oh);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_LVL; i++)
      if (oh[i]) r = LVL_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              init_o,
  output logic [BASE_W-1:0] base_o,
  output logic [DATA_W-1:0] casw_o,
  output logic              single_o,
  output logic              aeoi_o,
  output logic [N_LVL-1:0]  imr_o,
  output logic              rd_isr_o,
  output logic              eoi_spec_o,
  output logic              eoi_ns_o,
  output logic [LVL_W-1:0]  eoi_lvl_o
);
  cfg_state_e st_q;
  logic need4_q;
  logic even_wr, start;

  assign even_wr = wr_i && !addr_i;
  assign start   = even_wr && wdata_i[4];
  assign ready_o = (st_q == ST_READY);
  assign init_o  = start;

  // command words decoded only once initialised
  assign eoi_spec_o = ready_o && even_wr && wdata_i[4:3] == 2'b00 && wdata_i[7:5] == 3'b011;
  assign eoi_ns_o   = ready_o && even_wr && wdata_i[4:3] == 2'b00 && wdata_i[7:5] == 3'b001;
  assign eoi_lvl_o  = wdata_i[LVL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      need4_q  <= 1'b0;
      single_o <= 1'b0;
      aeoi_o   <= 1'b0;
      base_o   <= '0;
      casw_o   <= '0;
      imr_o    <= '1;
      rd_isr_o <= 1'b0;
    end else if (wr_i) begin
      if (start) begin
        st_q     <= ST_BASE;
        need4_q  <= wdata_i[0];
        single_o <= wdata_i[1];
        aeoi_o   <= 1'b0;
        imr_o    <= '1;
        rd_isr_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_BASE: if (addr_i) begin
            base_o <= wdata_i[DATA_W-1:LVL_W];
            if (!single_o)    st_q <= ST_CASC;
            else if (need4_q) st_q <= ST_MODE;
            else              st_q <= ST_READY;
          end
          ST_CASC: if (addr_i) begin
            casw_o <= wdata_i;
            st_q   <= need4_q ? ST_MODE : ST_READY;
          end
          ST_MODE: if (addr_i) begin
            aeoi_o <= wdata_i[1];
            st_q   <= ST_READY;
          end
          ST_READY: begin
            if (addr_i) imr_o <= wdata_i;
            else if (wdata_i[4:3] == 2'b01 && wdata_i[1]) rd_isr_o <= wdata_i[0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] irq_i,
  input  logic             clr_i,
  input  logic [N_LVL-1:0] ack_oh_i,
  input  logic [N_LVL-1:0] isr_set_i,
  input  logic [N_LVL-1:0] isr_clr_i,
  output logic [N_LVL-1:0] irr_o,
  output logic [N_LVL-1:0] isr_o
);
  logic [N_LVL-1:0] irq_q, rise;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_o <= '0;
      isr_o <= '0;
    end else begin
      irq_q <= irq_i;
      if (clr_i) begin
        irr_o <= '0;
        isr_o <= '0;
      end else begin
        irr_o <= (irr_o | rise) & irq_i & ~ack_oh_i;
        isr_o <= (isr_o & ~isr_clr_i) | isr_set_i;
      end
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  logic [N_LVL-1:0] irr_i,
  input  logic [N_LVL-1:0] imr_i,
  input  logic [N_LVL-1:0] isr_i,
  output logic             win_vld_o,
  output logic [LVL_W-1:0] win_idx_o,
  output logic [N_LVL-1:0] win_oh_o
);
  logic [N_LVL-1:0] allow, elig;

  // a level may interrupt only if nothing at or above it is in service
  for (genvar i = 0; i < N_LVL; i++) begin : g_allow
    assign allow[i] = ~|isr_i[i:0];
  end

  assign elig      = irr_i & ~imr_i & allow;
  assign win_oh_o  = lsb_oh(elig);
  assign win_vld_o = |elig;
  assign win_idx_o = oh2idx(win_oh_o);
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_LVL-1:0]  irq_i,
  output logic              int_o,
  input  logic              inta_i,
  input  logic [LVL_W-1:0]  cas_i,
  output logic [LVL_W-1:0]  cas_o,
  output logic              vec_vld_o,
  output logic [DATA_W-1:0] vec_o
);
  logic              cfg_ready, cfg_init, single_q, aeoi_q, rd_isr_q;
  logic              eoi_spec, eoi_ns;
  logic [LVL_W-1:0]  eoi_lvl;
  logic [BASE_W-1:0] base_q;
  logic [DATA_W-1:0] casw_q;
  logic [N_LVL-1:0]  imr_q, irr_q, isr_q;
  logic              win_vld;
  logic [LVL_W-1:0]  win_idx;
  logic [N_LVL-1:0]  win_oh;
  logic              cascaded, sel_me, take, to_slave;
  logic [N_LVL-1:0]  ack_oh, isr_set, isr_clr;

  pic_cfg u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .ready_o(cfg_ready), .init_o(cfg_init), .base_o(base_q), .casw_o(casw_q),
    .single_o(single_q), .aeoi_o(aeoi_q), .imr_o(imr_q), .rd_isr_o(rd_isr_q),
    .eoi_spec_o(eoi_spec), .eoi_ns_o(eoi_ns), .eoi_lvl_o(eoi_lvl)
  );

  pic_prio u_prio (
    .irr_i(irr_q), .imr_i(imr_q), .isr_i(isr_q),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_oh_o(win_oh)
  );

  pic_req u_req (
    .clk_i, .rst_ni, .irq_i, .clr_i(cfg_init),
    .ack_oh_i(ack_oh), .isr_set_i(isr_set), .isr_clr_i(isr_clr),
    .irr_o(irr_q), .isr_o(isr_q)
  );

  assign cascaded = !single_q;
  assign sel_me   = !cascaded || master_i || (cas_i == casw_q[LVL_W-1:0]);
  assign take     = inta_i && cfg_ready && sel_me;
  assign to_slave = cascaded && master_i && win_vld && casw_q[win_idx];
  assign ack_oh   = (take && win_vld) ? win_oh : '0;
  assign isr_set  = aeoi_q ? '0 : ack_oh;

  always_comb begin
    isr_clr = '0;
    if (eoi_spec)    isr_clr[eoi_lvl] = 1'b1;
    else if (eoi_ns) isr_clr = lsb_oh(isr_q);
  end

  assign int_o   = cfg_ready && win_vld;
  assign cas_o   = (cascaded && master_i) ? win_idx : '0;
  assign rdata_o = addr_i ? imr_q : (rd_isr_q ? isr_q : irr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_vld_o <= 1'b0;
      vec_o     <= '0;
    end else begin
      vec_vld_o <= take && !to_slave;
      if (take) vec_o <= {base_q, win_vld ? win_idx : LVL_W'(N_LVL-1)};
    end
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
  import pic_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             int_o,
  input logic             inta_i,
  input logic             vec_vld_o,
  input logic [N_LVL-1:0] irq_i,
  input logic             ready,
  input logic             aeoi,
  input logic [N_LVL-1:0] imr,
  input logic [N_LVL-1:0] irr,
  input logic [N_LVL-1:0] isr
);
  AST_INT_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ready); // R1
  AST_MASK_FULL_IN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> imr == '1); // R2
  AST_INT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr & ~imr)); // R4
  AST_IRR_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr & ~$past(irq_i)) == '0); // R4
  AST_AEOI_NO_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi |-> isr == '0); // R7
  AST_VEC_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(inta_i)); // R3
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
  .clk_i, .rst_ni, .int_o, .inta_i, .vec_vld_o, .irq_i,
  .ready(cfg_ready), .aeoi(aeoi_q), .imr(imr_q), .irr(irr_q), .isr(isr_q)
);

// File: tb/pic_ctrl_tb.sv
`timescale 1ns/1ps
module pic_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_m = 0, wr_s = 0, addr = 0, inta = 0;
  logic [7:0] wd = 0, m_irq = 0, s_irq = 0;
  logic [7:0] rd_m, rd_s, vm, vs, m_in;
  logic int_m, int_s, vld_m, vld_s;
  logic [2:0] cas_m, cas_s;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign m_in = {m_irq[7:3], int_s, m_irq[1:0]};

  pic_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b1), .wr_i(wr_m), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rd_m), .irq_i(m_in), .int_o(int_m), .inta_i(inta),
    .cas_i(3'd0), .cas_o(cas_m), .vec_vld_o(vld_m), .vec_o(vm)
  );

  pic_ctrl u_slave (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b0), .wr_i(wr_s), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rd_s), .irq_i(s_irq), .int_o(int_s), .inta_i(inta),
    .cas_i(cas_m), .cas_o(cas_s), .vec_vld_o(vld_s), .vec_o(vs)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit s, input bit a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d;
    if (s) wr_s = 1'b1; else wr_m = 1'b1;
    @(negedge clk);
    wr_m = 1'b0; wr_s = 1'b0;
  endtask

  task automatic rd(input bit s, input bit a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = s ? rd_s : rd_m;
  endtask

  task automatic ack();
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual %h expected %h", 8'h0, 8'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 int low after reset", {7'd0, int_m}, 8'h00);
    rd(0, 1, v); chk("R2 mask after reset", v, 8'hFF);

    wr(0, 0, 8'h11); wr(0, 1, 8'h20);
    rd(0, 1, v); chk("R2 mask during init", v, 8'hFF);
    wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    rd(0, 1, v); chk("R2 mask after init", v, 8'hFF);
    wr(0, 1, 8'h5A); rd(0, 1, v); chk("R2 mask load", v, 8'h5A);
    wr(0, 1, 8'h00); wr(1, 1, 8'h00);

    // master inputs
    for (int n = 0; n < 8; n++) begin
      if (n == 2) continue;
      @(negedge clk); m_irq[n] = 1'b1;
      idle(2);
      chk("R4 int on edge", {7'd0, int_m}, 8'h01);
      wr(0, 0, 8'h0A); rd(0, 0, v); chk("R8 irr read", v, 8'(1 << n));
      ack();
      chk("R3 master vld", {7'd0, vld_m}, 8'h01);
      chk("R3 master vector", vm, 8'h20 + 8'(n));
      wr(0, 0, 8'h0B); rd(0, 0, v); chk("R6 isr set", v, 8'(1 << n));
      wr(0, 0, 8'h0A); rd(0, 0, v); chk("R4 irr cleared by ack", v, 8'h00);
      wr(0, 0, 8'h60 + 8'(n));
      wr(0, 0, 8'h0B); rd(0, 0, v); chk("R6 specific eoi", v, 8'h00);
      @(negedge clk); m_irq[n] = 1'b0;
      idle(1);
    end

    // slave inputs through cascade
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); s_irq[n] = 1'b1;
      idle(3);
      chk("R10 master int from slave", {7'd0, int_m}, 8'h01);
      chk("R10 cas_o", {5'd0, cas_m}, 8'h02);
      ack();
      chk("R10 master silent", {7'd0, vld_m}, 8'h00);
      chk("R10 slave vld", {7'd0, vld_s}, 8'h01);
      chk("R3 slave vector", vs, 8'h28 + 8'(n));
      wr(0, 0, 8'h0B); rd(0, 0, v); chk("R10 master isr", v, 8'h04);
      wr(1, 0, 8'h60 + 8'(n)); wr(0, 0, 8'h62);
      @(negedge clk); s_irq[n] = 1'b0;
      idle(2);
      rd(0, 0, v); chk("R6 master isr cleared", v, 8'h00);
    end

    // priority and nesting
    @(negedge clk); m_irq[5] = 1'b1; m_irq[3] = 1'b1;
    idle(2); ack(); chk("R5 higher wins", vm, 8'h23);
    idle(1); chk("R5 lower blocked", {7'd0, int_m}, 8'h00);
    @(negedge clk); m_irq[1] = 1'b1;
    idle(2); chk("R5 nesting int", {7'd0, int_m}, 8'h01);
    ack(); chk("R5 nested vector", vm, 8'h21);
    wr(0, 0, 8'h20); rd(0, 0, v); chk("R6 nonspecific eoi", v, 8'h08);
    chk("R5 still blocked", {7'd0, int_m}, 8'h00);
    wr(0, 0, 8'h63); idle(1);
    chk("R5 released", {7'd0, int_m}, 8'h01);
    ack(); chk("R5 low vector", vm, 8'h25);
    wr(0, 0, 8'h20); rd(0, 0, v); chk("R6 eoi last", v, 8'h00);
    @(negedge clk); m_irq = 8'h00;

    // masking
    wr(0, 1, 8'h10);
    @(negedge clk); m_irq[4] = 1'b1;
    idle(2); chk("R4 masked no int", {7'd0, int_m}, 8'h00);
    wr(0, 0, 8'h0A); rd(0, 0, v); chk("R4 masked latched", v, 8'h10);
    wr(0, 1, 8'h00); idle(1);
    chk("R2 unmask int", {7'd0, int_m}, 8'h01);
    ack(); chk("R3 vector 4", vm, 8'h24);
    wr(0, 0, 8'h64);
    @(negedge clk); m_irq = 8'h00;

    // ignored commands
    @(negedge clk); m_irq[6] = 1'b1;
    idle(2); ack(); chk("R3 vector 6", vm, 8'h26);
    wr(0, 0, 8'h0B);
    wr(0, 0, 8'h40); wr(0, 0, 8'h80); wr(0, 0, 8'h08);
    rd(0, 0, v); chk("R11 isr kept", v, 8'h40);
    rd(0, 1, v); chk("R11 mask kept", v, 8'h00);
    wr(0, 0, 8'h66);
    @(negedge clk); m_irq = 8'h00;
    idle(1);

    // spurious: request gone
    @(negedge clk); m_irq[6] = 1'b1;
    idle(2); @(negedge clk); m_irq[6] = 1'b0;
    idle(1); ack();
    chk("R9 spurious vld", {7'd0, vld_m}, 8'h01);
    chk("R9 spurious vector", vm, 8'h27);
    rd(0, 0, v); chk("R9 no isr", v, 8'h00);
    // spurious: masked away, input 7 masked too
    wr(0, 1, 8'h80);
    @(negedge clk); m_irq[5] = 1'b1;
    idle(2); wr(0, 1, 8'hA0);
    chk("R4 int drops when masked", {7'd0, int_m}, 8'h00);
    ack(); chk("R9 masked spurious", vm, 8'h27);
    rd(0, 0, v); chk("R9 no isr masked", v, 8'h00);
    @(negedge clk); m_irq = 8'h00;

    // single mode, auto-EOI
    wr(0, 0, 8'h13); wr(0, 1, 8'h47); wr(0, 1, 8'h03);
    rd(0, 1, v); chk("R1 single init done", v, 8'hFF);
    wr(0, 1, 8'h00);
    @(negedge clk); m_irq[3] = 1'b1;
    idle(2); chk("R1 ready after 3 words", {7'd0, int_m}, 8'h01);
    ack();
    chk("R3 base low bits ignored", vm, 8'h43);
    chk("R10 slave ignores", {7'd0, vld_s}, 8'h00);
    wr(0, 0, 8'h0B); rd(0, 0, v); chk("R7 aeoi no isr", v, 8'h00);
    chk("R7 int clear", {7'd0, int_m}, 8'h00);
    @(negedge clk); m_irq = 8'h00;

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule